// File: doc/BRIEF.md
# Block Write Packetizer for a Serial Target Link

This block sits on the host side of a serial link. It runs after a block write command has already been accepted by the target. It takes a payload of up to 65535 bytes from a valid/ready byte stream and cuts it into packets. The packet size limit is chosen per transfer from a 3-bit size code.

Each packet goes out on the transmit byte interface toward the serial shifter in three parts. First comes one header byte that tells the target where the packet sits in the sequence. Then come the data bytes. If checksums are on, two trailer bytes follow the data.

When the last packet has gone out, the block collects the target's data acknowledgement from the receive byte interface. It then reports completion, with a failure flag if the acknowledgement is wrong. Issuing the command and retrying after a failure are handled elsewhere.

Top module: `spi_blk_write_packetizer`

## Requirements
- R1: After reset, and whenever the block is idle, `tx_valid`, `in_ready`, `busy` and `done` are all 0.
- R2: Size code 0 to 5 on `size_sel` sets the packet limit to 256, 512, 1024, 2048, 4096 or 8192 bytes. Codes 6 and 7 select 8192. The code is sampled with `start`.
- R3: Every packet begins with a header byte 0xF0 | order. The order is 3 when the bytes still to send fit in one packet, 1 for the first packet of several, and 2 for any later packet that is not the last. The last packet of several therefore carries 0xF3.
- R4: Each packet carries min(bytes remaining, packet limit) data bytes after its header. The bytes appear in stream order and unchanged, and a stream byte is accepted only at the moment it is transmitted.
- R5: With `crc_en` set at start, each packet's data is followed by two 0x00 trailer bytes. With it clear, no trailer is sent.
- R6: The acknowledgement is 2 received bytes with checksums on and 3 with them off. `rx_valid` has no effect before the last packet byte has been sent.
- R7: The transfer passes when the final acknowledgement byte is 0x00 and the byte before it is 0xC3. `done` pulses one cycle after the final acknowledgement byte. `fail` is high in that same cycle exactly when the check did not pass.
- R8: A length of 1 is sent as a 2-byte packet (header 0xF3). The one stream byte comes first, followed by a 0x00 pad byte that is not taken from the stream.
- R9: A length of 0 sends no bytes and pulses `done` (with `fail` low) in the cycle after `start`.
- R10: `start` is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| xfer_len | input | LEN_W | Payload length in bytes |
| size_sel | input | 3 | Packet size code |
| crc_en | input | 1 | Append trailer bytes and expect the 2-byte acknowledgement |
| in_data | input | 8 | Payload stream byte |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Payload byte taken this cycle |
| tx_data | output | 8 | Byte to the serial shifter |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Shifter accepts the byte |
| rx_data | input | 8 | Byte received from the target |
| rx_valid | input | 1 | Received byte present |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Acknowledgement check failed (valid with done) |

## Verification
An off-by-one in the remaining or per-packet count shows up on the very next header byte, as a wrong order code or a packet boundary one byte early or late. The reference model catches it when that byte is accepted. A corrupted stream-remaining count shows up either as a pad byte where data should be, or as a payload byte that is never consumed, which stalls the block and fails through the completion timeout.

An acknowledgement counter that ends early or late moves the `done` pulse by one cycle, and the per-clock comparison against the expected completion cycle flags that at once. A checker that tests the wrong byte pair shows up as a wrong `fail` value at completion.

// File: rtl/spi_bwp_pkg.sv
package spi_bwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_DATA = 3'd2,
        ST_TRL  = 3'd3,
        ST_ACK  = 3'd4
    } bwp_state_e;

    localparam logic [7:0] HDR_BASE  = 8'hF0;
    localparam logic [1:0] ORD_ONLY  = 2'd3;
    localparam logic [1:0] ORD_FIRST = 2'd1;
    localparam logic [1:0] ORD_MID   = 2'd2;
    localparam logic [7:0] ACK_HEAD  = 8'hC3;
    localparam logic [7:0] ACK_TAIL  = 8'h00;
    localparam logic [7:0] FILL_BYTE = 8'h00;
    localparam int         TOP_CODE  = 5;

endpackage

// File: rtl/spi_bwp_size_dec.sv
module spi_bwp_size_dec #(
    parameter int W        = 17,
    parameter int DEF_CODE = 5
) (
    input  logic [2:0]   code,
    output logic [W-1:0] pkt_max
);
    import spi_bwp_pkg::*;

    localparam logic [W-1:0] UNIT = W'(256);

    always_comb begin
        if (int'(code) <= TOP_CODE) begin
            pkt_max = UNIT << code;
        end else begin
            pkt_max = UNIT << DEF_CODE;
        end
    end
endmodule

// File: rtl/spi_bwp_hdr_gen.sv
module spi_bwp_hdr_gen #(
    parameter int W = 17
) (
    input  logic [W-1:0] remain,
    input  logic [W-1:0] pkt_max,
    input  logic         first,
    output logic [7:0]   hdr_byte,
    output logic [1:0]   order,
    output logic [W-1:0] pkt_len
);
    import spi_bwp_pkg::*;

    logic fits;

    always_comb begin
        fits    = (remain <= pkt_max);
        pkt_len = fits ? remain : pkt_max;
        if (fits) begin
            order = ORD_ONLY;
        end else if (first) begin
            order = ORD_FIRST;
        end else begin
            order = ORD_MID;
        end
        hdr_byte = HDR_BASE | {6'b0, order};
    end
endmodule

// File: rtl/spi_bwp_ack_chk.sv
module spi_bwp_ack_chk (
    input  logic [7:0] prev_byte,
    input  logic [7:0] last_byte,
    output logic       ack_ok
);
    import spi_bwp_pkg::*;

    always_comb begin
        ack_ok = (prev_byte == ACK_HEAD) && (last_byte == ACK_TAIL);
    end
endmodule

// File: rtl/spi_blk_write_packetizer.sv
module spi_blk_write_packetizer #(
    parameter int LEN_W         = 16,
    parameter int DEF_SIZE_CODE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [2:0]       size_sel,
    input  logic             crc_en,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    output logic             busy,
    output logic             done,
    output logic             fail
);
    import spi_bwp_pkg::*;

    localparam int MAXSZ_W = 14;
    localparam int CNT_W   = ((LEN_W > MAXSZ_W) ? LEN_W : MAXSZ_W) + 1;

    typedef struct packed {
        bwp_state_e       state;
        logic [CNT_W-1:0] remain;
        logic [LEN_W-1:0] feed;
        logic [CNT_W-1:0] pkt_left;
        logic [CNT_W-1:0] pkt_max;
        logic             first;
        logic             crc_on;
        logic             trl_idx;
        logic [1:0]       ack_idx;
        logic [7:0]       ack_prev;
        logic             done;
        logic             fail;
    } bwp_regs_t;

    bwp_regs_t q, d;

    logic [CNT_W-1:0] sel_max;
    logic [7:0]       hdr_byte;
    logic [1:0]       hdr_order;
    logic [CNT_W-1:0] hdr_len;
    logic             ack_ok;
    logic             beat;
    logic [1:0]       ack_need;

    spi_bwp_size_dec #(.W(CNT_W), .DEF_CODE(DEF_SIZE_CODE)) u_size (
        .code    (size_sel),
        .pkt_max (sel_max)
    );

    spi_bwp_hdr_gen #(.W(CNT_W)) u_hdr (
        .remain   (q.remain),
        .pkt_max  (q.pkt_max),
        .first    (q.first),
        .hdr_byte (hdr_byte),
        .order    (hdr_order),
        .pkt_len  (hdr_len)
    );

    spi_bwp_ack_chk u_ack (
        .prev_byte (q.ack_prev),
        .last_byte (rx_data),
        .ack_ok    (ack_ok)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.fail   = 1'b0;
        tx_valid = 1'b0;
        tx_data  = FILL_BYTE;
        in_ready = 1'b0;
        ack_need = q.crc_on ? 2'd1 : 2'd2;

        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if (xfer_len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.state   = ST_HDR;
                        d.remain  = (xfer_len == LEN_W'(1)) ? CNT_W'(2) : CNT_W'(xfer_len);
                        d.feed    = xfer_len;
                        d.pkt_max = sel_max;
                        d.first   = 1'b1;
                        d.crc_on  = crc_en;
                        d.ack_idx = 2'd0;
                    end
                end
            end
            ST_HDR: begin
                tx_valid = 1'b1;
                tx_data  = hdr_byte;
                if (tx_ready) begin
                    d.pkt_left = hdr_len;
                    d.first    = 1'b0;
                    d.state    = ST_DATA;
                end
            end
            ST_DATA: begin
                if (q.feed != '0) begin
                    tx_valid = in_valid;
                    tx_data  = in_data;
                    in_ready = tx_ready;
                end else begin
                    tx_valid = 1'b1;
                    tx_data  = FILL_BYTE;
                end
                if (tx_valid && tx_ready) begin
                    d.remain   = q.remain - CNT_W'(1);
                    d.pkt_left = q.pkt_left - CNT_W'(1);
                    if (q.feed != '0) begin
                        d.feed = q.feed - LEN_W'(1);
                    end
                    if (q.pkt_left == CNT_W'(1)) begin
                        if (q.crc_on) begin
                            d.state   = ST_TRL;
                            d.trl_idx = 1'b0;
                        end else if (q.remain == CNT_W'(1)) begin
                            d.state = ST_ACK;
                        end else begin
                            d.state = ST_HDR;
                        end
                    end
                end
            end
            ST_TRL: begin
                tx_valid = 1'b1;
                tx_data  = FILL_BYTE;
                if (tx_ready) begin
                    if (q.trl_idx) begin
                        d.state = (q.remain == '0) ? ST_ACK : ST_HDR;
                    end else begin
                        d.trl_idx = 1'b1;
                    end
                end
            end
            ST_ACK: begin
                if (rx_valid) begin
                    d.ack_prev = rx_data;
                    d.ack_idx  = q.ack_idx + 2'd1;
                    if (q.ack_idx == ack_need) begin
                        d.done  = 1'b1;
                        d.fail  = !ack_ok;
                        d.state = ST_IDLE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign beat = tx_valid && tx_ready;
    assign busy = (q.state != ST_IDLE);
    assign done = q.done;
    assign fail = q.fail;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> (!tx_valid && !in_ready));

    // R4
    stream_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (beat && q.state == ST_DATA && q.feed != '0));

    // R4
    pkt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DATA) |-> (q.pkt_left != '0 && q.pkt_left <= q.pkt_max));

    // R3
    later_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HDR && !q.first) |-> (hdr_order != ORD_FIRST));

    // R7
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R10
    remain_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE) |=> (q.remain <= $past(q.remain)));

endmodule

// File: tb/spi_blk_write_packetizer_test.sv
`timescale 1ns/1ps
module spi_blk_write_packetizer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] xfer_len;
    logic [2:0]  size_sel;
    logic        crc_en;
    logic [7:0]  in_data;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        busy;
    logic        done;
    logic        fail;

    always #2.5 clk = ~clk;

    spi_blk_write_packetizer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .size_sel(size_sel), .crc_en(crc_en), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy), .done(done), .fail(fail)
    );

    int         checks = 0;
    int         fails  = 0;
    int         cyc    = 0;
    logic [7:0] exp_q[$];
    logic [7:0] src_q[$];
    logic [7:0] rsp_q[$];
    bit         active = 0;
    bit         junk   = 0;
    bit         due    = 0;
    bit         got_done = 0;
    bit         exp_fail_v = 0;
    string      cur_req = "R4";

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Reference plan of the transmit byte stream, built from the requirements
    task automatic plan(input int len, input int code, input bit crc, input int seed);
        int eff, lim, pos, n;
        bit first;
        logic [7:0] pay[$];
        for (int i = 0; i < len; i++) begin
            pay.push_back(8'((seed + i * 7) & 255));
            src_q.push_back(8'((seed + i * 7) & 255));
        end
        eff   = (len == 1) ? 2 : len;                 // R8
        lim   = (code <= 5) ? (256 << code) : 8192;   // R2
        pos   = 0;
        first = 1;
        while (pos < eff) begin
            n = ((eff - pos) <= lim) ? (eff - pos) : lim;
            if ((eff - pos) <= lim) exp_q.push_back(8'hF3);   // R3
            else if (first)         exp_q.push_back(8'hF1);
            else                    exp_q.push_back(8'hF2);
            for (int i = 0; i < n; i++)
                exp_q.push_back((pos + i < len) ? pay[pos + i] : 8'h00);
            if (crc) begin                                     // R5
                exp_q.push_back(8'h00);
                exp_q.push_back(8'h00);
            end
            pos  += n;
            first = 0;
        end
    endtask

    // Input driver, 2 ns after each rising edge
    initial begin
        tx_ready = 0; in_valid = 0; in_data = 0; rx_valid = 0; rx_data = 0;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            tx_ready = (cyc % 3) != 2;
            in_valid = (src_q.size() > 0) && ((cyc % 5) != 4);
            in_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
            if (junk) begin
                rx_valid = 1; rx_data = 8'h55;
            end else if (active && exp_q.size() == 0 && rsp_q.size() > 0) begin
                rx_valid = 1; rx_data = rsp_q[0];
            end else begin
                rx_valid = 0;
            end
        end
    end

    // Per-clock comparison against the reference model, at the falling edge
    always @(negedge clk) begin
        bit nd;
        if (rst_n) begin
            nd = 0;
            if (done || due) begin
                checks++;
                if (done !== due) begin
                    fails++;
                    $display("FAIL %s/R7/R9 done timing: actual %0b expected %0b", cur_req, done, due);
                end
            end
            if (done) begin
                got_done = 1;
                checks++;
                if (fail !== exp_fail_v) begin
                    fails++;
                    $display("FAIL R7 fail flag: actual %0b expected %0b", fail, exp_fail_v);
                end
            end
            if (rx_valid && !junk && rsp_q.size() > 0) begin
                nd = (rsp_q.size() == 1);
                void'(rsp_q.pop_front());
            end
            if (start && xfer_len == 0 && !active) nd = 1;   // R9
            due = nd;
            if (tx_valid && tx_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL %s extra tx byte: actual %02h expected none", cur_req, tx_data);
                end else begin
                    if (tx_data !== exp_q[0]) begin
                        fails++;
                        $display("FAIL %s tx byte: actual %02h expected %02h", cur_req, tx_data, exp_q[0]);
                    end
                    void'(exp_q.pop_front());
                end
            end
            if (in_valid && in_ready && src_q.size() > 0) void'(src_q.pop_front());
        end
    end

    task automatic run(input int len, input int code, input bit crc,
                       input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] r2,
                       input bit efail, input string req,
                       input int inj_start, input int inj_rx);
        int guard;
        plan(len, code, crc, len + code);
        rsp_q.delete();
        if (len != 0) begin
            rsp_q.push_back(r0);
            rsp_q.push_back(r1);
            if (!crc) rsp_q.push_back(r2);   // R6
        end
        exp_fail_v = efail;
        cur_req    = req;
        got_done   = 0;
        @(posedge clk); #1;
        start = 1; xfer_len = 16'(len); size_sel = 3'(code); crc_en = crc;
        active = (len != 0);
        guard = 0;
        while (!got_done && guard < 40000) begin
            @(posedge clk); #1;
            guard++;
            start = 0;
            junk  = 0;
            if (guard == inj_start) begin start = 1; xfer_len = 16'd0; end   // R10
            if (guard == inj_rx) junk = 1;                                   // R6
        end
        start = 0; junk = 0;
        checks++;
        if (!got_done) begin
            fails++;
            $display("FAIL %s no completion: actual 0 expected 1", req);
        end
        checks++;
        if (exp_q.size() != 0 || src_q.size() != 0) begin
            fails++;
            $display("FAIL %s bytes left: actual %0d/%0d expected 0/0", req, exp_q.size(), src_q.size());
        end
        exp_q.delete(); src_q.delete();
        active = 0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 0; start = 0; xfer_len = 0; size_sel = 0; crc_en = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        checks++;   // R1 reset state
        if (tx_valid !== 0 || in_ready !== 0 || busy !== 0 || done !== 0) begin
            fails++;
            $display("FAIL R1 reset: actual %0b%0b%0b%0b expected 0000", tx_valid, in_ready, busy, done);
        end
        // R3 R4 R5 R6 single packet with trailer, stray rx during data ignored
        run(5, 0, 1, 8'hC3, 8'h00, 8'h00, 0, "R3_R5", 0, 3);
        // R2 R3 R6 three packets of a 256 limit, 3-byte acknowledgement
        run(600, 0, 0, 8'h11, 8'hC3, 8'h00, 0, "R2_R3", 0, 10);
        // R8 one-byte write padded
        run(1, 2, 1, 8'hC3, 8'h00, 8'h00, 0, "R8", 0, 0);
        // R9 zero length
        run(0, 0, 1, 8'h00, 8'h00, 8'h00, 0, "R9", 0, 0);
        // R7 wrong tail byte
        run(5, 0, 1, 8'hC3, 8'h01, 8'h00, 1, "R7", 0, 0);
        // R6 R7 wrong byte pair when three bytes are read
        run(4, 0, 0, 8'hC3, 8'h00, 8'h00, 1, "R6_R7", 0, 0);
        // R2 R10 512 limit with trailers, start pulse while busy ignored
        run(1100, 1, 1, 8'hC3, 8'h00, 8'h00, 0, "R2_R10", 20, 0);
        // R2 code 7 falls back to the largest size
        run(300, 7, 0, 8'h00, 8'hC3, 8'h00, 0, "R2", 0, 0);
        // R1 idle after all transfers
        @(negedge clk);
        checks++;
        if (busy !== 0 || tx_valid !== 0) begin
            fails++;
            $display("FAIL R1 idle: actual %0b%0b expected 00", busy, tx_valid);
        end
        summary();
    end

endmodule